// File: doc/BRIEF.md
# DRAM ECC Error Logging Unit

This unit sits beside a memory controller's ECC checker and turns its error strobes into architected state. A correctable (single-bit) or uncorrectable (multi-bit) strobe arrives together with one shared description of the failing access: the cache-line address (physical bits 32:7), the channel, the 8-bit ECC syndrome and an 8-bit code for the requester. Three further strobes flag a refresh timeout, a lock error outside DRAM and a thermal sensor trip. Each event sets its own status bit. The first ECC event after a clean state is logged. A later uncorrectable error replaces a logged correctable one, so the log always describes the most severe error that is still pending.

Software reaches the unit through a plain register port. It selects one of eight registers, reads the selected register in the same cycle, and writes the status register and the three enable registers. Status bits are cleared by writing ones. Three report outputs (system error, management interrupt, configuration interrupt) each have their own enable mask. An output gives a one-cycle pulse when an enabled status bit goes from 0 to 1. Software is expected to enable any one event on only one of the three paths.

Top module: `ecc_err_log`

## Requirements
- R1: Status register (select 0) uses bit 0 = correctable ECC, bit 1 = uncorrectable ECC, bit 8 = refresh timeout, bit 9 = lock error, bit 11 = thermal. Every other bit reads 0. Each strobe sets its bit on the clock edge where the strobe is sampled high.
- R2: Writing status with a 1 in a bit position clears that bit. A 0 leaves the bit unchanged.
- R3: If a strobe and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R4: A correctable error that arrives while status bits 1:0 are both 0 logs four values:
  - the address register (select 4) gets line bits 24:0 in bits 31:7, zeros in bits 6:1 and the channel in bit 0;
  - the extension register (select 5) gets line bit 25 in bit 0 and zeros elsewhere;
  - the syndrome register (select 6) gets the syndrome;
  - the destination register (select 7) gets the requester code.
- R5: A correctable error that arrives while status bit 0 or bit 1 is set leaves all four log registers unchanged, but still sets status bit 0.
- R6: An uncorrectable error that arrives while status bit 1 is clear writes its own values into all four log registers, replacing any logged correctable error.
- R7: An uncorrectable error that arrives while status bit 1 is already set leaves the log unchanged.
- R8: Enable registers are writable in these bits, and all other bits read 0:
  - system-error enable (select 1): bits 0, 1, 8, 9, 11;
  - management-interrupt enable (select 2): bits 0, 1 only;
  - configuration-interrupt enable (select 3): bits 0, 1 only.
- R9: A report output is high for exactly one cycle, in the first cycle in which a status bit reads 1 after being 0, and only if the matching bit of that path's enable register was set.
- R10: A strobe for a status bit that is already set produces no pulse on any path.
- R11: Writes to selects 4 to 7 have no effect on the logged values.
- R12: After reset, all registers read 0 and all report outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable ECC error strobe |
| ue_evt | input | 1 | Uncorrectable ECC error strobe |
| evt_line | input | 26 | Failing cache-line address, physical bits 32:7 |
| evt_chan | input | 1 | Failing channel |
| evt_syn | input | 8 | ECC syndrome of the failing access |
| evt_src | input | 8 | Requester code of the failing access (0 = processor read) |
| refresh_timeout | input | 1 | Refresh timeout strobe |
| lock_err | input | 1 | Lock error outside DRAM strobe |
| thermal_evt | input | 1 | Thermal sensor event strobe |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| serr_pulse | output | 1 | System-error report pulse |
| smi_pulse | output | 1 | Management-interrupt report pulse |
| sci_pulse | output | 1 | Configuration-interrupt report pulse |

## Verification
The report paths are swept over every pairing of path and event source, with the path's enables fully set and then cleared. This separates which mask bits each path really implements from the pulse timing. Each source is then fired a second time while its bit is still set, which distinguishes edge detection from level reporting. The log is driven through a sequence with distinct address, syndrome and requester values at each step:
- a correctable error on a clean log;
- a correctable error over it;
- an uncorrectable error over the correctable one;
- a second uncorrectable error.

A stale or wrongly prioritised capture therefore shows up as a mismatched field. Clearing writes are placed alone, with all-zero data, and in the same cycle as a strobe, which covers each resolution of the set-versus-clear race.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  localparam int unsigned STS_W  = 16;
  localparam int unsigned LINE_W = 26;
  localparam int unsigned SYN_W  = 8;
  localparam int unsigned SRC_W  = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NPATH  = 3;

  localparam int unsigned B_CE    = 0;
  localparam int unsigned B_UE    = 1;
  localparam int unsigned B_REFTO = 8;
  localparam int unsigned B_LOCK  = 9;
  localparam int unsigned B_THERM = 11;

  localparam logic [STS_W-1:0] ECC_MASK = 16'h0003;
  localparam logic [STS_W-1:0] ALL_MASK = 16'h0B03;

  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_SERR_EN = 3'd1,
    SEL_SMI_EN  = 3'd2,
    SEL_SCI_EN  = 3'd3,
    SEL_ADDR    = 3'd4,
    SEL_EXT     = 3'd5,
    SEL_SYN     = 3'd6,
    SEL_SRC     = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic              chan;
    logic [SYN_W-1:0]  syn;
    logic [SRC_W-1:0]  src;
  } err_info_t;

  // Address register image: line bits 24:0 at 31:7, channel at bit 0.
  function automatic logic [DATA_W-1:0] addr_image(input logic [LINE_W-1:0] line,
                                                   input logic chan);
    return {line[LINE_W-2:0], 6'b000000, chan};
  endfunction

  // Extension register image: physical bit 32 in bit 0.
  function automatic logic [7:0] ext_image(input logic [LINE_W-1:0] line);
    return {7'b0000000, line[LINE_W-1]};
  endfunction

  // Enable mask implemented by each report path.
  function automatic logic [STS_W-1:0] path_mask(input int unsigned idx);
    return (idx == 0) ? ALL_MASK : ECC_MASK;
  endfunction

endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status
  import ecc_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_vec,
  input  logic [STS_W-1:0] clr_vec,
  output logic [STS_W-1:0] sts_q,
  output logic [STS_W-1:0] rise_vec
);

  logic [STS_W-1:0] set_m;
  logic [STS_W-1:0] clr_m;

  assign set_m    = set_vec & ALL_MASK;
  assign clr_m    = clr_vec & ALL_MASK;
  assign rise_vec = set_m & ~sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_m) | set_m;
  end

  // R3: a set in the same cycle as a clear leaves the bit set
  a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_m) |=> ((sts_q & $past(set_m)) == $past(set_m)));

  // R2: a clearing write with no competing set empties the written bits
  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_m) && (set_m == '0)) |=> ((sts_q & $past(clr_m)) == '0));

  // R1: reserved status bits stay at zero
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~ALL_MASK) == '0);

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_hit,
  input  logic              ue_hit,
  input  err_info_t         info,
  input  logic [1:0]        ecc_sts,
  output logic [DATA_W-1:0] addr_q,
  output logic [7:0]        ext_q,
  output logic [SYN_W-1:0]  syn_q,
  output logic [SRC_W-1:0]  src_q,
  output logic              take
);

  logic take_ue;
  logic take_ce;

  assign take_ue = ue_hit && !ecc_sts[1];
  assign take_ce = ce_hit && !ue_hit && (ecc_sts == 2'b00);
  assign take    = take_ue || take_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ext_q  <= '0;
      syn_q  <= '0;
      src_q  <= '0;
    end else if (take) begin
      addr_q <= addr_image(info.line, info.chan);
      ext_q  <= ext_image(info.line);
      syn_q  <= info.syn;
      src_q  <= info.src;
    end
  end

  // R5: a correctable error over a pending ECC error keeps the log
  a_r5_ce_keeps_log: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_hit && !ue_hit && (ecc_sts != 2'b00)) |=> ($stable(addr_q) && $stable(syn_q) && $stable(src_q)));

  // R6: an uncorrectable error with no pending one is logged
  a_r6_ue_logged: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_hit && !ecc_sts[1]) |=> (syn_q == $past(info.syn) && src_q == $past(info.src)));

  // R7: a second uncorrectable error keeps the first
  a_r7_ue_keeps_log: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_hit && ecc_sts[1]) |=> ($stable(addr_q) && $stable(ext_q) && $stable(syn_q)));

endmodule

// File: rtl/ecc_log_report.sv
module ecc_log_report
  import ecc_log_pkg::*;
#(
  parameter logic [STS_W-1:0] MASK = ECC_MASK,
  parameter logic [2:0]       SEL  = 3'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       sel,
  input  logic [STS_W-1:0] wdata,
  input  logic [STS_W-1:0] rise_vec,
  output logic [STS_W-1:0] en_q,
  output logic             pulse_q
);

  logic hit;

  assign hit = |(rise_vec & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (wr && sel == SEL) en_q <= wdata & MASK;
      pulse_q <= hit;
    end
  end

  // R10: with no new status edge the path stays quiet next cycle
  a_r10_no_edge_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vec == '0) |=> !pulse_q);

  // R8: unimplemented enable bits never hold a one
  a_r8_enable_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~MASK) == '0);

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [25:0]       evt_line,
  input  logic              evt_chan,
  input  logic [7:0]        evt_syn,
  input  logic [7:0]        evt_src,
  input  logic              refresh_timeout,
  input  logic              lock_err,
  input  logic              thermal_evt,
  input  logic [2:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              serr_pulse,
  output logic              smi_pulse,
  output logic              sci_pulse
);

  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] clr_vec;
  logic [STS_W-1:0] sts_q;
  logic [STS_W-1:0] rise_vec;
  err_info_t        info;
  logic [DATA_W-1:0] addr_q;
  logic [7:0]        ext_q;
  logic [SYN_W-1:0]  syn_q;
  logic [SRC_W-1:0]  src_q;
  logic              log_take;
  logic [STS_W-1:0]  en_q  [NPATH];
  logic [NPATH-1:0]  pulse;

  always_comb begin
    set_vec          = '0;
    set_vec[B_CE]    = ce_evt;
    set_vec[B_UE]    = ue_evt;
    set_vec[B_REFTO] = refresh_timeout;
    set_vec[B_LOCK]  = lock_err;
    set_vec[B_THERM] = thermal_evt;
  end

  assign clr_vec = (reg_wr && reg_sel == SEL_STATUS) ? reg_wdata : '0;
  assign info    = '{line: evt_line, chan: evt_chan, syn: evt_syn, src: evt_src};

  ecc_log_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .sts_q    (sts_q),
    .rise_vec (rise_vec)
  );

  ecc_log_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_hit  (ce_evt),
    .ue_hit  (ue_evt),
    .info    (info),
    .ecc_sts (sts_q[1:0]),
    .addr_q  (addr_q),
    .ext_q   (ext_q),
    .syn_q   (syn_q),
    .src_q   (src_q),
    .take    (log_take)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    ecc_log_report #(
      .MASK (path_mask(p)),
      .SEL  (3'(int'(SEL_SERR_EN) + p))
    ) u_report (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .sel      (reg_sel),
      .wdata    (reg_wdata),
      .rise_vec (rise_vec),
      .en_q     (en_q[p]),
      .pulse_q  (pulse[p])
    );
  end

  assign serr_pulse = pulse[0];
  assign smi_pulse  = pulse[1];
  assign sci_pulse  = pulse[2];

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_STATUS:  reg_rdata = {16'h0, sts_q};
      SEL_SERR_EN: reg_rdata = {16'h0, en_q[0]};
      SEL_SMI_EN:  reg_rdata = {16'h0, en_q[1]};
      SEL_SCI_EN:  reg_rdata = {16'h0, en_q[2]};
      SEL_ADDR:    reg_rdata = addr_q;
      SEL_EXT:     reg_rdata = {24'h0, ext_q};
      SEL_SYN:     reg_rdata = {24'h0, syn_q};
      default:     reg_rdata = {24'h0, src_q};
    endcase
  end

  // R9: a pulse on any path follows a fresh status bit
  a_r9_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |-> ((sts_q & ALL_MASK) != '0));

  // R4: a capture never happens while an uncorrectable error is pending
  a_r4_capture_gate: assert property (@(posedge clk) disable iff (!rst_n)
    log_take |-> !sts_q[1]);

  // R9: a pulse never lasts two cycles unless a new edge occurred
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_pulse && rise_vec == '0) |=> !serr_pulse);

endmodule

// File: tb/ecc_err_log_test.sv
`timescale 1ns/1ps
module ecc_err_log_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_evt = 0, ue_evt = 0;
  logic [25:0] evt_line = '0;
  logic        evt_chan = 0;
  logic [7:0]  evt_syn = '0, evt_src = '0;
  logic        refresh_timeout = 0, lock_err = 0, thermal_evt = 0;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        serr_pulse, smi_pulse, sci_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecc_err_log uut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    reg_sel = sel; reg_wr = 1; reg_wdata = d;
    tick();
    reg_wr = 0; reg_wdata = '0;
  endtask

  // event index: 0 ce, 1 ue, 2 refresh, 3 lock, 4 thermal
  function automatic int ev_bit(input int e);
    case (e)
      0: return 0; 1: return 1; 2: return 8; 3: return 9; default: return 11;
    endcase
  endfunction

  task automatic fire(input int e);
    ce_evt = (e == 0); ue_evt = (e == 1);
    refresh_timeout = (e == 2); lock_err = (e == 3); thermal_evt = (e == 4);
    tick();
    ce_evt = 0; ue_evt = 0; refresh_timeout = 0; lock_err = 0; thermal_evt = 0;
  endtask

  function automatic logic [31:0] exp_addr(input logic [25:0] l, input logic c);
    return ({6'b0, l} << 7) & 32'hFFFF_FF80 | {31'b0, c};
  endfunction

  task automatic set_info(input logic [25:0] l, input logic c, input logic [7:0] s, input logic [7:0] r);
    evt_line = l; evt_chan = c; evt_syn = s; evt_src = r;
  endtask

  task automatic chk_log(input string req, input logic [25:0] l, input logic c,
                         input logic [7:0] s, input logic [7:0] r);
    logic [31:0] d;
    rd(3'd4, d); chk(req, d, exp_addr(l, c));
    rd(3'd5, d); chk(req, d, {31'b0, l[25]});
    rd(3'd6, d); chk(req, d, {24'b0, s});
    rd(3'd7, d); chk(req, d, {24'b0, r});
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] mask;
    bit en_bit;
    tick(); tick();
    rst_n = 1;
    tick();

    // R12: reset state
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), d); chk("R12 reg", d, 32'h0);
    end
    chk("R12 pulses", {29'b0, serr_pulse, smi_pulse, sci_pulse}, 32'h0);

    // R8: enable masks
    for (int p = 0; p < 3; p++) begin
      wr(3'(p + 1), 16'hFFFF);
      rd(3'(p + 1), d);
      chk("R8 mask", d, (p == 0) ? 32'h0B03 : 32'h0003);
      wr(3'(p + 1), 16'h0000);
    end

    // R9 / R10 sweep: path x event x enable
    for (int p = 0; p < 3; p++) begin
      for (int e = 0; e < 5; e++) begin
        for (int en = 0; en < 2; en++) begin
          wr(3'd0, 16'hFFFF);
          wr(3'(p + 1), en ? 16'hFFFF : 16'h0000);
          mask = (p == 0) ? 16'h0B03 : 16'h0003;
          en_bit = (en == 1) && mask[ev_bit(e)];
          fire(e);
          chk("R9 target path", {31'b0, (p == 0) ? serr_pulse : (p == 1) ? smi_pulse : sci_pulse},
              {31'b0, en_bit});
          chk("R9 other paths", {31'b0, (p == 0) ? (smi_pulse | sci_pulse) :
                                        (p == 1) ? (serr_pulse | sci_pulse) : (serr_pulse | smi_pulse)}, 32'h0);
          rd(3'd0, d); chk("R1 status bit", d, 32'h1 << ev_bit(e));
          tick();
          chk("R9 one cycle", {29'b0, serr_pulse, smi_pulse, sci_pulse}, 32'h0);
          fire(e);
          chk("R10 no repeat", {29'b0, serr_pulse, smi_pulse, sci_pulse}, 32'h0);
          wr(3'(p + 1), 16'h0000);
        end
      end
    end

    // R1: all events together
    wr(3'd0, 16'hFFFF);
    ce_evt = 1; ue_evt = 1; refresh_timeout = 1; lock_err = 1; thermal_evt = 1;
    tick();
    ce_evt = 0; ue_evt = 0; refresh_timeout = 0; lock_err = 0; thermal_evt = 0;
    rd(3'd0, d); chk("R1 all bits", d, 32'h0B03);

    // R2: write-one-to-clear
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R2 zero write", d, 32'h0B03);
    wr(3'd0, 16'h0101);
    rd(3'd0, d); chk("R2 partial clear", d, 32'h0A02);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, d); chk("R2 full clear", d, 32'h0);

    // R4: first correctable error logged
    set_info(26'h3A5_5A5A, 1'b1, 8'hC3, 8'h00);
    fire(0);
    chk_log("R4 ce log", 26'h3A5_5A5A, 1'b1, 8'hC3, 8'h00);

    // R5: second correctable error ignored by log
    set_info(26'h012_3456, 1'b0, 8'h11, 8'h05);
    fire(0);
    chk_log("R5 ce held", 26'h3A5_5A5A, 1'b1, 8'hC3, 8'h00);
    rd(3'd0, d); chk("R5 status", d, 32'h1);

    // R6: uncorrectable overwrites correctable
    set_info(26'h1FE_0F0F, 1'b0, 8'h7E, 8'h03);
    fire(1);
    chk_log("R6 ue over ce", 26'h1FE_0F0F, 1'b0, 8'h7E, 8'h03);
    rd(3'd0, d); chk("R6 status", d, 32'h3);

    // R7: later uncorrectable does not overwrite
    set_info(26'h2AA_AAAA, 1'b1, 8'h99, 8'h06);
    fire(1);
    chk_log("R7 ue held", 26'h1FE_0F0F, 1'b0, 8'h7E, 8'h03);

    // R5: correctable after uncorrectable only clears bit 0 pending
    wr(3'd0, 16'h0001);
    fire(0);
    chk_log("R5 ce under ue", 26'h1FE_0F0F, 1'b0, 8'h7E, 8'h03);

    // R11: log registers ignore writes
    for (int s = 4; s < 8; s++) wr(3'(s), 16'hFFFF);
    chk_log("R11 read only", 26'h1FE_0F0F, 1'b0, 8'h7E, 8'h03);

    // R3: capture and clear in the same cycle
    wr(3'd0, 16'hFFFF);
    reg_sel = 3'd0; reg_wr = 1; reg_wdata = 16'h0003; ce_evt = 1;
    tick();
    reg_wr = 0; reg_wdata = '0; ce_evt = 0;
    rd(3'd0, d); chk("R3 set wins", d, 32'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule